// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bit Receiver

This block takes frames from a single open-drain data line that rests high. Every bit cell has a low phase followed by a high phase. The cell carries a one when its low phase is the longer of the two, and a zero when its high phase is. The line first passes through a two-flop synchroniser. The block then times each low level and each high level in clock cycles and decides the bit by comparing the two durations of the same cell. Because it compares durations instead of sampling at a fixed point, it tolerates transmitters that stretch the whole cell. Decoded bits are packed most-significant-bit first into bytes, and each byte is presented with its index in the frame.

A capture is armed by a one-cycle `arm` pulse. The receiver waits a bounded time for the line to fall. A frame is closed by a final short low (the stop bit) followed by a high level longer than the idle limit. At that point the block issues a one-cycle `done` pulse that carries the number of decoded bits and a status code. It then returns to rest until it is armed again.

A parameter chooses how bits are decided. The default compares the two durations directly. The alternative models a mid-scale up/down accumulator and adds a guard band and range checks.

Top module: `pwm_bit_rx`

## Requirements
- R1: The line is sampled through two flops. A line edge that completes a byte shows on `byte_vld` after the third rising clock edge following the edge, and not before.
- R2: Line activity while the block is not armed produces no `byte_vld` and no `done`. A capture begins only after an `arm` pulse while at rest, and the falling line edge is its first timed level.
- R3: If the line has not fallen within START_LIMIT cycles of arming, `done` pulses with status 1 (timeout) and `bit_count` 0.
- R4: In ratio mode (DECIDE_MODE 0), a cell decodes as 1 when its low phase lasted strictly more cycles than its high phase, and as 0 otherwise (ties give 0). Cells stretched by a common factor decode the same way.
- R5: Bits fill bytes most-significant bit first. Each complete byte raises `byte_vld` for one cycle with `byte_data`, and `byte_idx` counts 0, 1, 2 and so on from the start of the capture.
- R6: A high level lasting more than IDLE_LIMIT cycles after the stop bit ends the capture with status 0 (ok). `bit_count` then equals (timed levels − 1) / 2, which is the number of decoded bits.
- R7: A low level lasting more than IDLE_LIMIT cycles ends the capture with status 3 (framing error, even level count). `bit_count` gives the bits decoded so far, and a partly filled byte is dropped.
- R8: The timed level that would bring the level count to MAX_LEVELS stops the capture with status 2 (overflow), and that level's cell is not decoded. The default MAX_LEVELS of 600 covers 34-byte frames (545 levels).
- R9: A high phase shorter than RUNT_MIN cycles that ends in a fall stops the capture with status 4 (glitch), and no bit is decoded for that cell.
- R10: In accumulator mode (DECIDE_MODE 1), the cell value is 2^(ACC_W−1) − low + high, and a value below mid-scale decodes as 1. A value within ±GUARD of mid-scale gives status 5 (ambiguous). So does a low phase that drives the value to zero, or a high phase that drives it to 2^ACC_W.
- R11: `done` is a single-cycle pulse. After it the block is at rest and can be armed for a new capture that starts again at byte index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | One-cycle request to start a capture |
| rx_in | input | 1 | Asynchronous data line, idles high |
| byte_vld | output | 1 | One-cycle strobe for a completed byte |
| byte_data | output | 8 | Completed byte, first received bit in bit 7 |
| byte_idx | output | IDX_W | Position of the byte within the frame |
| done | output | 1 | One-cycle end-of-capture strobe |
| bit_count | output | LVL_W | Bits decoded in the finished capture |
| status | output | 3 | 0 ok, 1 timeout, 2 overflow, 3 framing, 4 glitch, 5 ambiguous |

## Verification
Each bit is decided on the clock edge at which the synchronised line first shows the closing fall. That puts `byte_vld` three rising edges after the line edge that ends a byte's last high phase. The bench drives the line on falling clock edges and checks that strobe on the third falling edge after the drive, and also checks that it is still low on the two before. `done` follows the end of a level by IDLE_LIMIT plus a few cycles, or follows arming by START_LIMIT plus a few cycles. For these the bench polls at falling edges under a bounded wait and records every strobe it sees. It also checks that the timeout does not come before the start limit has run out.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

   typedef enum logic [2:0] {
      RX_OK       = 3'd0,
      RX_TIMEOUT  = 3'd1,
      RX_OVERFLOW = 3'd2,
      RX_FRAME    = 3'd3,
      RX_GLITCH   = 3'd4,
      RX_AMBIG    = 3'd5
   } rx_status_e;

   typedef enum logic [1:0] {
      PH_REST,
      PH_WAIT,
      PH_LOW,
      PH_HIGH
   } rx_phase_e;

   localparam int MODE_RATIO = 0;
   localparam int MODE_ACCUM = 1;

endpackage

// File: rtl/pbr_sync.sv
module pbr_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pbr_decide.sv
module pbr_decide import pbr_pkg::*; #(
   parameter int CNT_W = 12,
   parameter int MODE  = MODE_RATIO,
   parameter int ACC_W = 8,
   parameter int GUARD = 2
) (
   input  logic [CNT_W-1:0] low_len,
   input  logic [CNT_W-1:0] high_len,
   output logic             bit_val,
   output logic             ambig
);

   generate
      if (MODE == MODE_RATIO) begin : g_ratio
         assign bit_val = (low_len > high_len);
         assign ambig   = 1'b0;
      end else begin : g_accum
         localparam int SW  = ((CNT_W > ACC_W) ? CNT_W : ACC_W) + 3;
         localparam int MID = 1 << (ACC_W - 1);
         localparam logic signed [SW-1:0] MID_S  = SW'(MID);
         localparam logic signed [SW-1:0] FULL_S = SW'(2 * MID);
         localparam logic signed [SW-1:0] GRD_S  = SW'(GUARD);

         logic signed [SW-1:0] lo_s, hi_s, res, dev;
         logic under, over, near;

         assign lo_s  = signed'({{(SW-CNT_W){1'b0}}, low_len});
         assign hi_s  = signed'({{(SW-CNT_W){1'b0}}, high_len});
         assign res   = MID_S - lo_s + hi_s;
         assign dev   = res - MID_S;
         assign under = (lo_s >= MID_S);
         assign over  = (res >= FULL_S);
         assign near  = (dev <= GRD_S) && (dev >= -GRD_S);

         assign bit_val = (res < MID_S);
         assign ambig   = under | over | near;
      end
   endgenerate

endmodule

// File: rtl/pbr_byte_pack.sv
module pbr_byte_pack #(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bit_vld,
   input  logic             bit_val,
   output logic             byte_vld,
   output logic [7:0]       byte_data,
   output logic [IDX_W-1:0] byte_idx
);

   logic [6:0]       shreg;
   logic [2:0]       fill;
   logic [IDX_W-1:0] next_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg     <= '0;
         fill      <= '0;
         next_idx  <= '0;
         byte_vld  <= 1'b0;
         byte_data <= '0;
         byte_idx  <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (clr) begin
            fill     <= '0;
            next_idx <= '0;
         end else if (bit_vld) begin
            shreg <= {shreg[5:0], bit_val};
            fill  <= fill + 3'd1;
            if (fill == 3'd7) begin
               byte_vld  <= 1'b1;
               byte_data <= {shreg, bit_val};
               byte_idx  <= next_idx;
               next_idx  <= next_idx + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pwm_bit_rx.sv
module pwm_bit_rx import pbr_pkg::*; #(
   parameter int IDLE_LIMIT  = 6250,
   parameter int START_LIMIT = 12500,
   parameter int MAX_LEVELS  = 600,
   parameter int RUNT_MIN    = 32,
   parameter int DECIDE_MODE = MODE_RATIO,
   parameter int ACC_W       = 8,
   parameter int GUARD       = 2,
   localparam int LVL_W      = $clog2(MAX_LEVELS + 1),
   localparam int IDX_W      = LVL_W - 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             rx_in,
   output logic             byte_vld,
   output logic [7:0]       byte_data,
   output logic [IDX_W-1:0] byte_idx,
   output logic             done,
   output logic [LVL_W-1:0] bit_count,
   output logic [2:0]       status
);

   localparam int LIM_MAX = (IDLE_LIMIT > START_LIMIT) ? IDLE_LIMIT : START_LIMIT;
   localparam int CNT_W   = $clog2(LIM_MAX + 1);

   generate
      if (MAX_LEVELS < 8) begin : g_bad_levels
         $error("MAX_LEVELS must be at least 8");
      end
      if (RUNT_MIN < 1 || RUNT_MIN >= IDLE_LIMIT) begin : g_bad_runt
         $error("RUNT_MIN must lie between 1 and IDLE_LIMIT");
      end
      if (DECIDE_MODE != MODE_RATIO && DECIDE_MODE != MODE_ACCUM) begin : g_bad_mode
         $error("DECIDE_MODE must select ratio or accumulator");
      end
      if (ACC_W < 2 || GUARD < 0) begin : g_bad_acc
         $error("ACC_W must be at least 2 and GUARD not negative");
      end
   endgenerate

   rx_phase_e        phase;
   logic             rx_s;
   logic [CNT_W-1:0] timer;
   logic [CNT_W-1:0] low_len;
   logic [LVL_W-1:0] levels;
   logic [LVL_W-1:0] lvl_next;
   logic [LVL_W-1:0] bits;
   logic             dec_bit, dec_amb;
   logic             level_end, lvl_full, runt, bit_vld, busy;

   pbr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rx_in),
      .q     (rx_s)
   );

   pbr_decide #(
      .CNT_W (CNT_W),
      .MODE  (DECIDE_MODE),
      .ACC_W (ACC_W),
      .GUARD (GUARD)
   ) u_decide (
      .low_len  (low_len),
      .high_len (timer),
      .bit_val  (dec_bit),
      .ambig    (dec_amb)
   );

   assign busy      = (phase != PH_REST);
   assign lvl_next  = levels + 1'b1;
   assign lvl_full  = (lvl_next == LVL_W'(MAX_LEVELS));
   assign level_end = ((phase == PH_LOW) && rx_s) || ((phase == PH_HIGH) && !rx_s);
   assign runt      = (timer < CNT_W'(RUNT_MIN));
   assign bit_vld   = (phase == PH_HIGH) && !rx_s && !lvl_full && !runt && !dec_amb;

   pbr_byte_pack #(.IDX_W(IDX_W)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (arm && !busy),
      .bit_vld   (bit_vld),
      .bit_val   (dec_bit),
      .byte_vld  (byte_vld),
      .byte_data (byte_data),
      .byte_idx  (byte_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_REST;
         timer     <= '0;
         low_len   <= '0;
         levels    <= '0;
         bits      <= '0;
         done      <= 1'b0;
         bit_count <= '0;
         status    <= RX_OK;
      end else begin
         done <= 1'b0;
         unique case (phase)
            PH_REST: begin
               if (arm) begin
                  phase  <= PH_WAIT;
                  timer  <= '0;
                  levels <= '0;
                  bits   <= '0;
               end
            end
            PH_WAIT: begin
               if (!rx_s) begin
                  phase <= PH_LOW;
                  timer <= CNT_W'(1);
               end else if (timer == CNT_W'(START_LIMIT)) begin
                  phase     <= PH_REST;
                  done      <= 1'b1;
                  status    <= RX_TIMEOUT;
                  bit_count <= bits;
               end else begin
                  timer <= timer + 1'b1;
               end
            end
            PH_LOW, PH_HIGH: begin
               if (level_end) begin
                  if (lvl_full) begin
                     phase     <= PH_REST;
                     done      <= 1'b1;
                     status    <= RX_OVERFLOW;
                     bit_count <= bits;
                  end else if (phase == PH_LOW) begin
                     low_len <= timer;
                     levels  <= lvl_next;
                     phase   <= PH_HIGH;
                     timer   <= CNT_W'(1);
                  end else if (runt) begin
                     phase     <= PH_REST;
                     done      <= 1'b1;
                     status    <= RX_GLITCH;
                     bit_count <= bits;
                  end else if (dec_amb) begin
                     phase     <= PH_REST;
                     done      <= 1'b1;
                     status    <= RX_AMBIG;
                     bit_count <= bits;
                  end else begin
                     bits   <= bits + 1'b1;
                     levels <= lvl_next;
                     phase  <= PH_LOW;
                     timer  <= CNT_W'(1);
                  end
               end else if (timer == CNT_W'(IDLE_LIMIT)) begin
                  phase     <= PH_REST;
                  done      <= 1'b1;
                  status    <= (phase == PH_HIGH) ? RX_OK : RX_FRAME;
                  bit_count <= bits;
               end else begin
                  timer <= timer + 1'b1;
               end
            end
            default: phase <= PH_REST;
         endcase
      end
   end

endmodule

// File: rtl/pbr_rx_chk.sv
module pbr_rx_chk #(
   parameter int LVL_W      = 10,
   parameter int MAX_LEVELS = 600
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             byte_vld,
   input logic             done,
   input logic [2:0]       status,
   input logic [LVL_W-1:0] bit_count
);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);

   // R2
   rest_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !byte_vld);

   // R11
   done_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3
   timeout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 3'd1) |-> (bit_count == '0));

   // R8
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(bit_count) <= MAX_LEVELS / 2));

endmodule

bind pwm_bit_rx pbr_rx_chk #(
   .LVL_W      (LVL_W),
   .MAX_LEVELS (MAX_LEVELS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .byte_vld  (byte_vld),
   .done      (done),
   .status    (status),
   .bit_count (bit_count)
);

// File: tb/pwm_bit_rx_test.sv
module pwm_bit_rx_test;

   localparam int IDLE  = 200;
   localparam int START = 300;
   localparam int MAXL  = 40;
   localparam int RUNT  = 4;
   localparam int LW    = $clog2(MAXL + 1);
   localparam int IW    = LW - 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 1'b0;
   logic rx = 1'b1;

   logic          bv, dn, a_bv, a_dn;
   logic [7:0]    bd, a_bd;
   logic [IW-1:0] bi, a_bi;
   logic [LW-1:0] bc, a_bc;
   logic [2:0]    st, a_st;

   int vectors = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pwm_bit_rx #(.IDLE_LIMIT(IDLE), .START_LIMIT(START), .MAX_LEVELS(MAXL),
                .RUNT_MIN(RUNT), .DECIDE_MODE(0), .ACC_W(8), .GUARD(2)) uut (
      .clk(clk), .rst_n(rst_n), .arm(arm), .rx_in(rx),
      .byte_vld(bv), .byte_data(bd), .byte_idx(bi),
      .done(dn), .bit_count(bc), .status(st));

   pwm_bit_rx #(.IDLE_LIMIT(IDLE), .START_LIMIT(START), .MAX_LEVELS(MAXL),
                .RUNT_MIN(RUNT), .DECIDE_MODE(1), .ACC_W(8), .GUARD(2)) uut_acc (
      .clk(clk), .rst_n(rst_n), .arm(arm), .rx_in(rx),
      .byte_vld(a_bv), .byte_data(a_bd), .byte_idx(a_bi),
      .done(a_dn), .bit_count(a_bc), .status(a_st));

   // observation records, filled at falling edges
   logic [7:0] got [0:7];
   int nb = 0, idx_bad = 0, ndone = 0, rst_st = 0, rbc = 0;
   int a_ndone = 0, a_rst = 0, a_rbc = 0, a_nb = 0;

   always @(negedge clk) begin
      if (bv) begin
         if (int'(bi) != nb) idx_bad = idx_bad + 1;
         if (nb < 8) got[nb] = bd;
         nb = nb + 1;
      end
      if (dn)   begin ndone = ndone + 1; rst_st = int'(st); rbc = int'(bc); end
      if (a_bv) a_nb = a_nb + 1;
      if (a_dn) begin a_ndone = a_ndone + 1; a_rst = int'(a_st); a_rbc = int'(a_bc); end
   end

   task automatic check(input string req, input int act, input int exp);
      vectors = vectors + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_obs();
      nb = 0; idx_bad = 0; ndone = 0; a_ndone = 0; a_nb = 0;
   endtask

   task automatic level(input logic v, input int n);
      rx = v;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input int lo, input int hi);
      level(1'b0, lo);
      level(1'b1, hi);
   endtask

   task automatic send_byte(input logic [7:0] b, input int s);
      for (int i = 7; i >= 0; i--) begin
         if (b[i]) send_bit(3 * s, s);
         else      send_bit(s, 3 * s);
      end
   endtask

   task automatic do_arm();
      @(negedge clk);
      arm = 1'b1;
      @(negedge clk);
      arm = 1'b0;
      clear_obs();
   endtask

   task automatic stop_and_wait();
      level(1'b0, 8);
      rx = 1'b1;
      for (int i = 0; i < 600 && ndone == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic wait_done();
      for (int i = 0; i < 600 && ndone == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      check("R11 reset byte_vld", int'(bv), 0);
      check("R11 reset done", int'(dn), 0);
      check("R11 reset status", int'(st), 0);
   endtask

   task automatic t_unarmed();
      clear_obs();
      send_byte(8'h5A, 8);
      level(1'b0, 8);
      level(1'b1, IDLE + 20);
      check("R2 unarmed bytes", nb, 0);
      check("R2 unarmed done", ndone, 0);
   endtask

   task automatic t_basic();
      do_arm();
      send_byte(8'hA5, 8);
      send_byte(8'h3C, 8);
      // falling edge closing the last cell of byte 1
      rx = 1'b0;
      @(negedge clk);
      check("R1 no strobe after 1 edge", int'(bv), 0);
      @(negedge clk);
      check("R1 no strobe after 2 edges", int'(bv), 0);
      @(negedge clk);
      check("R1 strobe after 3 edges", int'(bv), 1);
      repeat (5) @(negedge clk);
      rx = 1'b1;
      wait_done();
      check("R5 byte count", nb, 2);
      check("R5 byte 0 MSB first", int'(got[0]), 8'hA5);
      check("R5 byte 1", int'(got[1]), 8'h3C);
      check("R5 index order", idx_bad, 0);
      check("R6 status ok", rst_st, 0);
      check("R6 bit count", rbc, 16);
      check("R11 one done", ndone, 1);
      check("R10 accum ok status", a_rst, 0);
      check("R10 accum bit count", a_rbc, 16);
   endtask

   task automatic t_stretch();
      do_arm();
      send_byte(8'hC3, 12);
      stop_and_wait();
      check("R4 stretched byte", int'(got[0]), 8'hC3);
      check("R4 stretched status", rst_st, 0);
      do_arm();
      for (int i = 0; i < 8; i++) send_bit(10, 10);
      stop_and_wait();
      check("R4 equal phases give 0", int'(got[0]), 8'h00);
   endtask

   task automatic t_frame();
      do_arm();
      send_bit(24, 8);
      send_bit(8, 24);
      send_bit(24, 8);
      rx = 1'b0;
      wait_done();
      rx = 1'b1;
      check("R7 framing status", rst_st, 3);
      check("R7 bit count", rbc, 3);
      check("R7 partial byte dropped", nb, 0);
   endtask

   task automatic t_start_timeout();
      int waited;
      waited = 0;
      do_arm();
      for (int i = 0; i < 600 && ndone == 0; i++) begin
         @(negedge clk);
         waited = waited + 1;
      end
      check("R3 timeout status", rst_st, 1);
      check("R3 timeout bit count", rbc, 0);
      check("R3 not before limit", int'(waited >= START), 1);
   endtask

   task automatic t_glitch();
      do_arm();
      send_bit(24, 8);
      send_bit(8, 2);
      level(1'b0, 8);
      rx = 1'b1;
      wait_done();
      check("R9 glitch status", rst_st, 4);
      check("R9 glitch bit count", rbc, 1);
   endtask

   task automatic t_overflow();
      do_arm();
      for (int i = 0; i < 20; i++) begin
         if (i % 3 == 0) send_bit(24, 8);
         else            send_bit(8, 24);
      end
      level(1'b0, 8);
      rx = 1'b1;
      wait_done();
      repeat (IDLE + 20) @(negedge clk);
      check("R8 overflow status", rst_st, 2);
      check("R8 overflow bit count", rbc, 19);
      check("R8 bytes before overflow", nb, 2);
      check("R8 byte 0", int'(got[0]), 8'h92);
      check("R11 single done", ndone, 1);
   endtask

   task automatic t_accum();
      do_arm();
      send_bit(24, 8);
      send_bit(10, 11);
      send_bit(24, 8);
      stop_and_wait();
      check("R10 guard band status", a_rst, 5);
      check("R10 guard band count", a_rbc, 1);
      check("R4 ratio mode decodes close cell", rst_st, 0);
      check("R4 ratio mode count", rbc, 3);
      do_arm();
      send_bit(130, 8);
      stop_and_wait();
      check("R10 low reaches zero status", a_rst, 5);
      check("R10 low reaches zero count", a_rbc, 0);
      check("R4 ratio long low", rbc, 1);
      check("R11 rearm restarts index", a_nb, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors = errors + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_unarmed();
      t_basic();
      t_stretch();
      t_frame();
      t_start_timeout();
      t_glitch();
      t_overflow();
      t_accum();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule